// File: doc/BRIEF.md
# Multi-Queue Interrupt Event Logger

This block gathers interrupt events from four queued sources (HDLC receive, HDLC transmit, command/indication receive and monitor receive), turns each one into a descriptor word and stores it in one of three circular queues held in external memory, through a write port that takes one word per cycle. Each queue has its own base address, its own length and a read pointer that software moves forward to acknowledge entries. The block keeps the write pointers. Monitor-transmit events do not go to a queue. They set a bit in a per-transmitter flag register.

Software learns about new entries, dropped entries and FIFO faults from a status register that clears when it is read. The interrupt output stays high while any status bit is set. A free-running counter serves as the watchdog timebase. The same counter can instead supply a time-stamp word that follows each command/indication or monitor entry. The two uses exclude each other: while time-stamping is enabled, the watchdog output stays low.

Top module: `irq_event_logger`

## Requirements
- R1: Sources 0 (HDLC receive) and 1 (HDLC transmit) go to queue 0, source 2 (command/indication) goes to queue 1, and source 3 (monitor receive) goes to queue 2. The descriptor word holds the source code in its top 2 bits, then the CH_W-bit channel, then the cause in the low bits.
- R2: Each write lands at the queue base plus the write pointer. The write pointer steps by one per stored word and wraps to 0 after length-1.
- R3: A stored entry sets its queue's entry bit in the status register (bit 0 HDLC, bit 1 command/indication, bit 2 monitor receive), and that raises irq.
- R4: A queue has (read - write - 1) modulo length free slots. An entry that does not fit is dropped without any memory write, and it sets the queue's overflow bit (bit 4 HDLC, bit 5 command/indication, bit 6 monitor receive).
- R5: A FIFO overrun pulse sets status bit 7, and a FIFO underrun pulse sets status bit 8.
- R6: A monitor-transmit event sets bit mtx_id of the 16-bit flag register mtx_q, and it sets status bit 3. Pulsing mtx_rd clears mtx_q.
- R7: When ts_en is high at grant, a command/indication or monitor entry is followed in the next cycle and the next slot by a word that holds the timebase count taken at grant. HDLC entries never carry a stamp. Two stamps differ by the number of cycles between their events, modulo TS_MAX.
- R8: A stamped entry is stored only when both of its slots are free. Otherwise neither word is written.
- R9: With ts_en low, wdt_o goes high when the timebase wraps without a wdt_kick, and a kick clears it. While ts_en is high, wdt_o stays low.
- R10: Events from different sources in the same cycle are each held as pending, and they are written one per cycle in fixed priority order, lowest source number first.
- R11: Pulsing stat_rd clears the status register in the next cycle. A bit that is set in that same cycle is kept. irq falls only once all status bits are clear.
- R12: After reset, mem_we, irq, wdt_o, the status register, mtx_q and all write pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | 4 | One-cycle event strobe per queued source |
| evt_chan | input | 4 x CH_W | Channel number per source |
| evt_cause | input | 4 x CAUSE_W | Cause code per source |
| mtx_req | input | 1 | Monitor-transmit event strobe |
| mtx_id | input | $clog2(MTX_N) | Monitor transmitter number |
| fifo_ovr | input | 1 | FIFO overrun pulse |
| fifo_und | input | 1 | FIFO underrun pulse |
| ts_en | input | 1 | Time-stamp mode, disables the watchdog |
| wdt_kick | input | 1 | Watchdog restart |
| q_base | input | 3 x ADDR_W | Queue base addresses |
| q_len | input | 3 x PTR_W | Queue lengths in words |
| q_rdptr | input | 3 x PTR_W | Software read pointers |
| q_wptr | output | 3 x PTR_W | Write pointers |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| stat_rd | input | 1 | Status read strobe, clears status |
| stat_q | output | 9 | Status register |
| mtx_rd | input | 1 | Flag register read strobe, clears it |
| mtx_q | output | MTX_N | Monitor-transmit flag register |
| irq | output | 1 | Operating interrupt |
| wdt_o | output | 1 | Watchdog overflow |

## Verification
The assertions check several things on every cycle: every write lands inside a configured queue window, the write pointers stay below their lengths, a write raises irq, a stamp word always follows a stamped descriptor, irq falls only after a status read, and wdt_o is low while time-stamping is on. Other behaviours only the bench's scenarios can show: the priority order of simultaneous events, the exact slot arithmetic that drops an entry or a stamped pair, wrap-around of a two-word entry, the spacing between stamp values, and flag-register and FIFO-fault reporting.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;

    localparam int NSRC  = 4;
    localparam int NQ    = 3;
    localparam int SRC_W = 2;
    localparam int Q_W   = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_HDLC_RX = 2'd0,
        SRC_HDLC_TX = 2'd1,
        SRC_CI_RX   = 2'd2,
        SRC_MON_RX  = 2'd3
    } src_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_STAMP = 1'b1
    } phase_e;

    // status register, msb first: bit 8 down to bit 0
    typedef struct packed {
        logic fifo_und;
        logic fifo_ovr;
        logic ovf_mon;
        logic ovf_ci;
        logic ovf_hdlc;
        logic mtx_evt;
        logic ent_mon;
        logic ent_ci;
        logic ent_hdlc;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    function automatic logic [Q_W-1:0] src_to_queue(input logic [SRC_W-1:0] s);
        case (s)
            SRC_CI_RX:  return 2'd1;
            SRC_MON_RX: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic queue_stamped(input logic [Q_W-1:0] q);
        return q != 2'd0;
    endfunction

endpackage

// File: rtl/irq_log_pend.sv
module irq_log_pend
    import irq_log_pkg::*;
#(
    parameter int CH_W    = 5,
    parameter int CAUSE_W = 9
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NSRC-1:0]                req,
    input  logic [NSRC-1:0][CH_W-1:0]      chan,
    input  logic [NSRC-1:0][CAUSE_W-1:0]   cause,
    input  logic [NSRC-1:0]                clr,
    output logic [NSRC-1:0]                pend,
    output logic [NSRC-1:0][CH_W-1:0]      chan_q,
    output logic [NSRC-1:0][CAUSE_W-1:0]   cause_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i]    <= 1'b0;
                chan_q[i]  <= '0;
                cause_q[i] <= '0;
            end else if (req[i]) begin
                pend[i]    <= 1'b1;
                chan_q[i]  <= chan[i];
                cause_q[i] <= cause[i];
            end else if (clr[i]) begin
                pend[i]    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_log_qptr.sv
module irq_log_qptr #(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  len,
    input  logic [PTR_W-1:0]  rdptr,
    input  logic              adv,
    output logic [PTR_W-1:0]  wptr,
    output logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  free
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            wptr <= '0;
        else if (adv)
            wptr <= (wptr == len - ONE) ? '0 : wptr + ONE;
    end

    assign addr = base + ADDR_W'(wptr);

    always_comb begin
        if (rdptr > wptr)
            free = rdptr - wptr - ONE;
        else
            free = len - wptr + rdptr - ONE;
    end

endmodule

// File: rtl/irq_log_tstamp.sv
module irq_log_tstamp #(
    parameter int TS_MAX = 62500,
    parameter int TS_W   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ts_en,
    input  logic            kick,
    output logic [TS_W-1:0] cnt,
    output logic            wdt_o
);

    localparam logic [TS_W-1:0] LAST = TS_W'(TS_MAX - 1);

    logic wrap;
    logic kick_ok;

    assign wrap    = (cnt == LAST);
    assign kick_ok = kick && !ts_en;

    always_ff @(posedge clk) begin
        if (rst || kick_ok)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || ts_en || kick)
            wdt_o <= 1'b0;
        else if (wrap)
            wdt_o <= 1'b1;
    end

endmodule

// File: rtl/irq_event_logger.sv
module irq_event_logger
    import irq_log_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CH_W   = 5,
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8,
    parameter int TS_MAX = 62500,
    parameter int MTX_N  = 16,
    localparam int CAUSE_W = DATA_W - SRC_W - CH_W,
    localparam int TS_W    = $clog2(TS_MAX),
    localparam int MTX_IW  = $clog2(MTX_N)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NSRC-1:0]               evt_req,
    input  logic [NSRC-1:0][CH_W-1:0]     evt_chan,
    input  logic [NSRC-1:0][CAUSE_W-1:0]  evt_cause,
    input  logic                          mtx_req,
    input  logic [MTX_IW-1:0]             mtx_id,
    input  logic                          fifo_ovr,
    input  logic                          fifo_und,
    input  logic                          ts_en,
    input  logic                          wdt_kick,
    input  logic [NQ-1:0][ADDR_W-1:0]     q_base,
    input  logic [NQ-1:0][PTR_W-1:0]      q_len,
    input  logic [NQ-1:0][PTR_W-1:0]      q_rdptr,
    output logic [NQ-1:0][PTR_W-1:0]      q_wptr,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic                          stat_rd,
    output logic [STAT_W-1:0]             stat_q,
    input  logic                          mtx_rd,
    output logic [MTX_N-1:0]              mtx_q,
    output logic                          irq,
    output logic                          wdt_o
);

    // pending capture
    logic [NSRC-1:0]              pend;
    logic [NSRC-1:0]              pend_clr;
    logic [NSRC-1:0][CH_W-1:0]    p_chan;
    logic [NSRC-1:0][CAUSE_W-1:0] p_cause;

    irq_log_pend #(.CH_W(CH_W), .CAUSE_W(CAUSE_W)) u_pend (
        .clk(clk), .rst(rst), .req(evt_req), .chan(evt_chan), .cause(evt_cause),
        .clr(pend_clr), .pend(pend), .chan_q(p_chan), .cause_q(p_cause)
    );

    // timebase shared by stamps and watchdog
    logic [TS_W-1:0] ts_cnt;

    irq_log_tstamp #(.TS_MAX(TS_MAX), .TS_W(TS_W)) u_ts (
        .clk(clk), .rst(rst), .ts_en(ts_en), .kick(wdt_kick),
        .cnt(ts_cnt), .wdt_o(wdt_o)
    );

    // queue pointers
    logic [NQ-1:0]              q_adv;
    logic [NQ-1:0][ADDR_W-1:0]  q_addr;
    logic [NQ-1:0][PTR_W-1:0]   q_free;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        irq_log_qptr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_qp (
            .clk(clk), .rst(rst), .base(q_base[q]), .len(q_len[q]),
            .rdptr(q_rdptr[q]), .adv(q_adv[q]), .wptr(q_wptr[q]),
            .addr(q_addr[q]), .free(q_free[q])
        );
    end

    // fixed-priority grant, lowest source first
    phase_e           phase;
    logic             gnt_any;
    logic [SRC_W-1:0] gnt_src;
    logic [Q_W-1:0]   gnt_q;
    logic [Q_W-1:0]   stamp_q;
    logic [TS_W-1:0]  stamp_val;
    logic             need_two;
    logic             fits;
    logic             take;

    always_comb begin
        gnt_any = 1'b0;
        gnt_src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                gnt_any = 1'b1;
                gnt_src = SRC_W'(i);
            end
        end
    end

    assign gnt_q    = src_to_queue(gnt_src);
    assign need_two = ts_en && queue_stamped(gnt_q);
    assign fits     = need_two ? (q_free[gnt_q] >= PTR_W'(2)) : (q_free[gnt_q] != '0);
    assign take     = (phase == PH_IDLE) && gnt_any;

    always_comb begin
        pend_clr = '0;
        if (take)
            pend_clr[gnt_src] = 1'b1;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_adv
        assign q_adv[q] = (take && fits && gnt_q == Q_W'(q))
                       || (phase == PH_STAMP && stamp_q == Q_W'(q));
    end

    // write sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            stamp_q   <= '0;
            stamp_val <= '0;
        end else if (phase == PH_STAMP) begin
            mem_we    <= 1'b1;
            mem_addr  <= q_addr[stamp_q];
            mem_wdata <= DATA_W'(stamp_val);
            phase     <= PH_IDLE;
        end else if (take && fits) begin
            mem_we    <= 1'b1;
            mem_addr  <= q_addr[gnt_q];
            mem_wdata <= {gnt_src, p_chan[gnt_src], p_cause[gnt_src]};
            if (need_two) begin
                phase     <= PH_STAMP;
                stamp_q   <= gnt_q;
                stamp_val <= ts_cnt;
            end
        end else begin
            mem_we <= 1'b0;
        end
    end

    // status and monitor-transmit flags
    stat_t            stat_r, stat_n;
    logic [NQ-1:0]    ent_set, ovf_set;
    logic [MTX_N-1:0] mtx_r, mtx_n;

    always_comb begin
        ent_set = '0;
        ovf_set = '0;
        if (take) begin
            if (fits) ent_set[gnt_q] = 1'b1;
            else      ovf_set[gnt_q] = 1'b1;
        end
        stat_n = stat_rd ? '0 : stat_r;
        stat_n.ent_hdlc = stat_n.ent_hdlc | ent_set[0];
        stat_n.ent_ci   = stat_n.ent_ci   | ent_set[1];
        stat_n.ent_mon  = stat_n.ent_mon  | ent_set[2];
        stat_n.ovf_hdlc = stat_n.ovf_hdlc | ovf_set[0];
        stat_n.ovf_ci   = stat_n.ovf_ci   | ovf_set[1];
        stat_n.ovf_mon  = stat_n.ovf_mon  | ovf_set[2];
        stat_n.mtx_evt  = stat_n.mtx_evt  | mtx_req;
        stat_n.fifo_ovr = stat_n.fifo_ovr | fifo_ovr;
        stat_n.fifo_und = stat_n.fifo_und | fifo_und;

        mtx_n = mtx_rd ? '0 : mtx_r;
        if (mtx_req)
            mtx_n[mtx_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_r <= '0;
            mtx_r  <= '0;
        end else begin
            stat_r <= stat_n;
            mtx_r  <= mtx_n;
        end
    end

    assign stat_q = stat_r;
    assign mtx_q  = mtx_r;
    assign irq    = |stat_r;

endmodule

// File: rtl/irq_log_chk.sv
module irq_log_chk
    import irq_log_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8,
    parameter int DATA_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      mem_we,
    input logic [ADDR_W-1:0]         mem_addr,
    input logic [DATA_W-1:0]         mem_wdata,
    input logic [NQ-1:0][ADDR_W-1:0] q_base,
    input logic [NQ-1:0][PTR_W-1:0]  q_len,
    input logic [NQ-1:0][PTR_W-1:0]  q_wptr,
    input logic                      irq,
    input logic                      stat_rd,
    input logic                      ts_en,
    input logic                      wdt_o,
    input phase_e                    phase
);

    logic [NQ-1:0] hit;

    for (genvar q = 0; q < NQ; q++) begin : g_win
        assign hit[q] = ({1'b0, mem_addr} >= {1'b0, q_base[q]})
                     && ({1'b0, mem_addr} < ({1'b0, q_base[q]} + (ADDR_W+1)'(q_len[q])));

        AST_WPTR_BOUND: assert property (@(posedge clk) disable iff (rst)
            q_wptr[q] < q_len[q]);  // R2
    end

    AST_ADDR_IN_QUEUE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (hit != '0));  // R2

    AST_WRITE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> irq);  // R3

    AST_STAMP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STAMP) |-> (mem_we && mem_wdata[DATA_W-1]));  // R7

    AST_STAMP_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STAMP) |=> (mem_we && phase == PH_IDLE));  // R7

    AST_TS_NO_WDT: assert property (@(posedge clk) disable iff (rst)
        $past(ts_en) |-> !wdt_o);  // R9

    AST_IRQ_FALL_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(stat_rd));  // R11

endmodule

bind irq_event_logger irq_log_chk #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .q_base(q_base), .q_len(q_len), .q_wptr(q_wptr),
    .irq(irq), .stat_rd(stat_rd), .ts_en(ts_en), .wdt_o(wdt_o), .phase(phase)
);

// File: tb/irq_event_logger_test.sv
`timescale 1ns/1ps
module irq_event_logger_test;
    import irq_log_pkg::*;

    localparam int DATA_W  = 16;
    localparam int CH_W    = 5;
    localparam int ADDR_W  = 8;
    localparam int PTR_W   = 4;
    localparam int TS_MAX  = 40;
    localparam int MTX_N   = 16;
    localparam int CAUSE_W = DATA_W - SRC_W - CH_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NSRC-1:0]              evt_req = '0;
    logic [NSRC-1:0][CH_W-1:0]    evt_chan = '0;
    logic [NSRC-1:0][CAUSE_W-1:0] evt_cause = '0;
    logic                         mtx_req = 1'b0;
    logic [3:0]                   mtx_id = '0;
    logic                         fifo_ovr = 1'b0, fifo_und = 1'b0;
    logic                         ts_en = 1'b0, wdt_kick = 1'b0;
    logic [NQ-1:0][ADDR_W-1:0]    q_base;
    logic [NQ-1:0][PTR_W-1:0]     q_len;
    logic [NQ-1:0][PTR_W-1:0]     q_rdptr;
    logic [NQ-1:0][PTR_W-1:0]     q_wptr;
    logic                         mem_we;
    logic [ADDR_W-1:0]            mem_addr;
    logic [DATA_W-1:0]            mem_wdata;
    logic                         stat_rd = 1'b0, mtx_rd = 1'b0;
    logic [STAT_W-1:0]            stat_q;
    logic [MTX_N-1:0]             mtx_q;
    logic                         irq, wdt_o;

    irq_event_logger #(
        .DATA_W(DATA_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
        .TS_MAX(TS_MAX), .MTX_N(MTX_N)
    ) uut (
        .clk(clk), .rst(rst), .evt_req(evt_req), .evt_chan(evt_chan),
        .evt_cause(evt_cause), .mtx_req(mtx_req), .mtx_id(mtx_id),
        .fifo_ovr(fifo_ovr), .fifo_und(fifo_und), .ts_en(ts_en),
        .wdt_kick(wdt_kick), .q_base(q_base), .q_len(q_len), .q_rdptr(q_rdptr),
        .q_wptr(q_wptr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .stat_rd(stat_rd), .stat_q(stat_q),
        .mtx_rd(mtx_rd), .mtx_q(mtx_q), .irq(irq), .wdt_o(wdt_o)
    );

    int total = 0;
    int bad   = 0;
    logic [ADDR_W-1:0] log_addr [64];
    logic [DATA_W-1:0] log_data [64];
    int nlog = 0;

    always @(negedge clk) begin
        if (!rst && mem_we && nlog < 64) begin
            log_addr[nlog] = mem_addr;
            log_data[nlog] = mem_wdata;
            nlog++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic post(input int s, input int ch, input int cs);
        @(negedge clk);
        evt_req[s]   = 1'b1;
        evt_chan[s]  = CH_W'(ch);
        evt_cause[s] = CAUSE_W'(cs);
        @(negedge clk);
        evt_req = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // read status: returns pre-clear value
    task automatic read_stat(output logic [STAT_W-1:0] v);
        @(negedge clk);
        v = stat_q;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // src(2) ch(5) cause(9) ts(1) addr(8) words(2)
    localparam int NV = 7;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 5'd3,  9'h011, 1'b0, 8'h00, 2'd1},
        {2'd1, 5'd7,  9'h022, 1'b0, 8'h01, 2'd1},
        {2'd2, 5'd1,  9'h033, 1'b0, 8'h20, 2'd1},
        {2'd3, 5'd31, 9'h1FF, 1'b0, 8'h40, 2'd1},
        {2'd2, 5'd2,  9'h0A5, 1'b1, 8'h21, 2'd2},
        {2'd3, 5'd4,  9'h15A, 1'b1, 8'h41, 2'd2},
        {2'd0, 5'd9,  9'h001, 1'b1, 8'h02, 2'd1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [STAT_W-1:0] sv;
        int n0;
        int werr;
        logic [DATA_W-1:0] t1, t2;

        q_base  = '{8'h40, 8'h20, 8'h00};
        q_len   = '{4'd5, 4'd6, 4'd8};
        q_rdptr = '0;

        idle(3);
        rst = 1'b0;
        idle(1);
        // R12 reset state
        chk("R12 mem_we", 32'(mem_we), 0);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 stat", 32'(stat_q), 0);
        chk("R12 mtx", 32'(mtx_q), 0);
        chk("R12 wdt", 32'(wdt_o), 0);
        chk("R12 wptr", 32'(q_wptr), 0);

        // vector table: R1 routing, R2 addressing, R7 stamps
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            ts_en = v[10];
            n0 = nlog;
            post(int'(v[26:25]), int'(v[24:20]), int'(v[19:11]));
            idle(4);
            chk($sformatf("R7 words vec%0d", i), 32'(nlog - n0), 32'(v[1:0]));
            chk($sformatf("R2 addr vec%0d", i), 32'(log_addr[n0]), 32'(v[9:2]));
            chk($sformatf("R1 desc vec%0d", i), 32'(log_data[n0]), 32'(v[26:11]));
            if (v[1:0] == 2'd2) begin
                chk($sformatf("R7 stamp slot vec%0d", i), 32'(log_addr[n0+1]), 32'(v[9:2]) + 1);
                chk($sformatf("R7 stamp range vec%0d", i),
                    32'(log_data[n0+1] < DATA_W'(TS_MAX)), 1);
            end
        end

        // R3 entry bits and irq, R11 clear on read
        idle(1);
        chk("R3 irq", 32'(irq), 1);
        read_stat(sv);
        chk("R3 entry bits", 32'(sv), 32'h007);
        chk("R11 stat cleared", 32'(stat_q), 0);
        chk("R11 irq low", 32'(irq), 0);

        // R8/R4 overflow on queue 2 (wptr 3, rdptr 0, len 5: one free slot)
        ts_en = 1'b1;
        n0 = nlog;
        post(3, 1, 9'h010);
        idle(4);
        chk("R8 pair dropped", 32'(nlog - n0), 0);
        chk("R4 ovf bit", 32'(stat_q), 32'h040);
        ts_en = 1'b0;
        post(3, 2, 9'h020);
        idle(3);
        chk("R4 last slot used", 32'(log_addr[nlog-1]), 32'h43);
        n0 = nlog;
        post(3, 3, 9'h030);
        idle(3);
        chk("R4 full drop", 32'(nlog - n0), 0);
        q_rdptr[2] = 4'd2;
        post(3, 4, 9'h040);
        idle(3);
        chk("R2 addr before wrap", 32'(log_addr[nlog-1]), 32'h44);
        post(3, 5, 9'h050);
        idle(3);
        chk("R2 wrap addr", 32'(log_addr[nlog-1]), 32'h40);
        chk("R2 wptr wrapped", 32'(q_wptr[2]), 1);
        read_stat(sv);

        // R7 stamp spacing and two-word wrap on queue 1
        q_rdptr[1] = 4'd3;
        ts_en = 1'b1;
        n0 = nlog;
        post(2, 6, 9'h060);
        idle(5);
        post(2, 7, 9'h070);
        idle(4);
        chk("R7 four words", 32'(nlog - n0), 4);
        t1 = log_data[n0+1];
        t2 = log_data[n0+3];
        chk("R7 stamp spacing", (32'(t2) + TS_MAX - 32'(t1)) % TS_MAX, 7);
        chk("R7 stamp wraps slot", 32'(log_addr[n0+3]), 32'h20);
        ts_en = 1'b0;
        read_stat(sv);

        // R10 priority with simultaneous events
        q_rdptr[2] = 4'd0;
        n0 = nlog;
        @(negedge clk);
        evt_req   = 4'b1111;
        evt_chan  = '{5'd13, 5'd12, 5'd11, 5'd10};
        evt_cause = '{9'h4, 9'h3, 9'h2, 9'h1};
        @(negedge clk);
        evt_req = '0;
        idle(6);
        chk("R10 count", 32'(nlog - n0), 4);
        for (int k = 0; k < 4; k++)
            chk($sformatf("R10 order %0d", k), 32'(log_data[n0+k][DATA_W-1 -: 2]), 32'(k));
        chk("R10 back to back", 32'(log_addr[n0+3]), 32'h41);
        chk("R10 hdlc tx slot", 32'(log_addr[n0+1]), 32'h04);

        // R11 set wins over simultaneous clear
        read_stat(sv);
        @(negedge clk);
        stat_rd  = 1'b1;
        fifo_ovr = 1'b1;
        @(negedge clk);
        stat_rd  = 1'b0;
        fifo_ovr = 1'b0;
        chk("R11 set kept", 32'(stat_q), 32'h080);
        // R5 FIFO faults
        @(negedge clk);
        fifo_und = 1'b1;
        @(negedge clk);
        fifo_und = 1'b0;
        chk("R5 overrun and underrun", 32'(stat_q), 32'h180);
        read_stat(sv);

        // R6 monitor transmit flags
        @(negedge clk);
        mtx_req = 1'b1; mtx_id = 4'd5;
        @(negedge clk);
        mtx_id = 4'd15;
        @(negedge clk);
        mtx_req = 1'b0;
        chk("R6 flags", 32'(mtx_q), 32'h8020);
        chk("R6 status bit", 32'(stat_q), 32'h008);
        @(negedge clk);
        mtx_rd = 1'b1;
        @(negedge clk);
        mtx_rd = 1'b0;
        chk("R6 flags cleared", 32'(mtx_q), 0);
        read_stat(sv);

        // R9 watchdog
        ts_en = 1'b0;
        @(negedge clk);
        wdt_kick = 1'b1;
        @(negedge clk);
        wdt_kick = 1'b0;
        chk("R9 kick clears", 32'(wdt_o), 0);
        idle(TS_MAX + 5);
        chk("R9 fires", 32'(wdt_o), 1);
        ts_en = 1'b1;
        idle(1);
        werr = 0;
        for (int k = 0; k < 2 * TS_MAX + 10; k++) begin
            @(negedge clk);
            if (wdt_o) werr++;
        end
        chk("R9 silent while stamping", 32'(werr), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule